// File: doc/BRIEF.md
# Counting-ramp ADC controller

This block is the digital side of a counting-ramp analog-to-digital converter. It drives an N-bit code into an external DAC. It takes back a one-bit comparator decision that goes high once the DAC voltage has reached the sampled input. A synchronous clear zeroes the counter, so the DAC starts each conversion from its lowest level.

While the convert level is high, the counter steps up by one per clock. It stops when the comparator trips or when the code reaches all ones. When the convert level falls, the count is copied into a separate result register, and only that register is presented as the converted value.

The comparator is asynchronous to the block's clock and passes through a multi-flop synchronizer. The counter therefore runs on past the first tripping code for as many clocks as the synchronizer has stages. A done flag marks the end of counting and holds until the next clear.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0, `result` is 0 and `done` is 0.
- R2: A clock edge with `cnt_clr` high sets `dac_code` to 0 and `done` to 0. This takes priority over counting, and `result` is not touched by it.
- R3: A clock edge with `conv_en` low leaves `dac_code` unchanged.
- R4: A clock edge with `conv_en` high increments `dac_code` by one, provided all of the following hold: `done` is low, the synchronized comparator is low, and the code is not all ones.
- R5: `cmp_hit` reaches the control logic only after `SYNC_STAGES` flops. If the comparator first goes high at code K > 0 and stays high, the final code is min(K + `SYNC_STAGES`, 2^N − 1). If it is already high when converting starts, the code stays 0.
- R6: The counter saturates at all ones and never wraps. With the comparator never tripping, the final code is 2^N − 1, reached after 2^N − 1 counting clocks.
- R7: `done` rises on the edge where either the synchronized comparator is high with `conv_en` high, or the code becomes all ones. After that it stays high, and `dac_code` stays frozen, until a clear or reset.
- R8: On the first clock edge that samples `conv_en` low after it was sampled high, `result` takes the counter value from before that edge. At every other edge, `result` holds. If a clear falls in the same edge, `result` still takes the pre-clear count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of counter and done flag before a conversion |
| conv_en | input | 1 | Convert level; high lets clocks step the counter |
| cmp_hit | input | 1 | Asynchronous comparator: high when DAC output has reached the input |
| dac_code | output | CODE_W | Counter value driven to the DAC |
| result | output | CODE_W | Converted value captured when `conv_en` falls |
| done | output | 1 | Counting finished (trip or saturation), sticky until clear |

## Verification
The clear and the result capture can fall on the same clock edge. This happens when `conv_en` is dropped in the same cycle that `cnt_clr` is raised. The bench provokes it at the end of a finished conversion. It then expects `result` to hold the pre-clear count, with `dac_code` at 0 and `done` low on the following cycle. A second collision is a comparator trip that lands while the code is stepping into all ones. Inputs just below full scale provoke it, and the bench expects saturation to win without wrapping.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
   localparam int unsigned DEF_CODE_W      = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_CODE_W      = 2;
endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              conv_en,
   input  logic              trip,
   output logic [CODE_W-1:0] cnt,
   output logic              done
);
   localparam logic [CODE_W-1:0] FULL = '1;

   logic              at_full;
   logic              run;
   logic [CODE_W-1:0] cnt_nxt;
   logic              done_nxt;

   always_comb begin
      at_full = (cnt == FULL);
      run     = conv_en && !trip && !done && !at_full;
      if (clr) begin
         cnt_nxt  = '0;
         done_nxt = 1'b0;
      end else begin
         cnt_nxt  = run ? cnt + 1'b1 : cnt;
         done_nxt = done || (conv_en && trip) || (cnt_nxt == FULL);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         cnt  <= cnt_nxt;
         done <= done_nxt;
      end
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0) && !done);
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_en && !clr) |=> $stable(cnt));
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_en && !trip && !done && cnt != FULL && !clr) |=> cnt == $past(cnt) + 1'b1);
   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && !clr) |=> cnt == FULL);
   assert_trip_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_en && trip && !clr) |=> done);
   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done && $stable(cnt));
endmodule

// File: rtl/ramp_capture.sv
module ramp_capture #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_en,
   input  logic [CODE_W-1:0] cnt,
   output logic [CODE_W-1:0] result
);
   logic conv_q;
   logic fall;

   assign fall = conv_q && !conv_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b0;
         result <= '0;
      end else begin
         conv_q <= conv_en;
         if (fall) result <= cnt;
      end
   end

   assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> result == $past(cnt));
   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(result));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
   import ramp_pkg::*;
#(
   parameter int unsigned CODE_W      = DEF_CODE_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clr,
   input  logic              conv_en,
   input  logic              cmp_hit,
   output logic [CODE_W-1:0] dac_code,
   output logic [CODE_W-1:0] result,
   output logic              done
);
   generate
      if (CODE_W < MIN_CODE_W) begin : g_bad_width
         $error("ramp_adc_ctrl: CODE_W below minimum");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("ramp_adc_ctrl: SYNC_STAGES below minimum");
      end
   endgenerate

   logic cmp_s;

   ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_hit),
      .q     (cmp_s)
   );

   ramp_counter #(.CODE_W(CODE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cnt_clr),
      .conv_en (conv_en),
      .trip    (cmp_s),
      .cnt     (dac_code),
      .done    (done)
   );

   ramp_capture #(.CODE_W(CODE_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .conv_en (conv_en),
      .cnt     (dac_code),
      .result  (result)
   );

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (dac_code == '0) && (result == '0) && !done);
endmodule

// File: tb/sim_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module sim_ramp_adc_ctrl;
   localparam int CODE_W = 8;
   localparam int SYNC   = 2;
   localparam int FULL   = (1 << CODE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_clr = 1'b0;
   logic conv_en = 1'b0;
   logic cmp_hit;
   logic [CODE_W-1:0] dac_code;
   logic [CODE_W-1:0] result;
   logic done;
   logic [CODE_W:0] vin = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   int exp_q[$];

   always #2 clk = ~clk;

   // behavioural DAC plus comparator
   assign cmp_hit = ({1'b0, dac_code} >= vin);

   ramp_adc_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .conv_en(conv_en),
      .cmp_hit(cmp_hit), .dac_code(dac_code), .result(result), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int v);
      if (v == 0) return 0;
      if (v + SYNC > FULL) return FULL;
      return v + SYNC;
   endfunction

   // monitor: detects a fall of conv_en at an edge, then compares result
   initial begin
      bit prev = 0;
      forever begin
         @(posedge clk);
         if (prev && !conv_en) begin
            prev = conv_en;
            @(negedge clk);
            if (exp_q.size() == 0) chk("R8 unexpected capture", int'(result), -1);
            else chk("R8 captured result", int'(result), exp_q.pop_front());
         end else begin
            prev = conv_en;
         end
      end
   end

   task automatic clear_and_set(input int v);
      @(negedge clk);
      vin = v[CODE_W:0];
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk("R2 clear code", int'(dac_code), 0);
      chk("R2 clear done", int'(done), 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic run_conv(input int v);
      int exp = model(v);
      clear_and_set(v);
      conv_en = 1'b1;
      repeat (FULL + 8) @(negedge clk);
      if (v > FULL || v + SYNC > FULL) chk("R6 saturated code", int'(dac_code), exp);
      else chk("R5 final code", int'(dac_code), exp);
      chk("R7 done after conversion", int'(done), 1);
      exp_q.push_back(exp);
      conv_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 done sticky", int'(done), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset code", int'(dac_code), 0);
      chk("R1 reset result", int'(result), 0);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_conv(0);
      run_conv(1);
      run_conv(37);
      run_conv(128);
      run_conv(253);
      run_conv(254);
      run_conv(300);

      // pause and resume: R3 hold, R4 stepping
      clear_and_set(300);
      conv_en = 1'b1;
      repeat (10) @(negedge clk);
      chk("R4 count after 10 clocks", int'(dac_code), 10);
      exp_q.push_back(10);
      conv_en = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3 hold while convert low", int'(dac_code), 10);
      chk("R8 result held", int'(result), 10);
      conv_en = 1'b1;
      repeat (7) @(negedge clk);
      chk("R4 resumed count", int'(dac_code), 17);
      exp_q.push_back(17);
      conv_en = 1'b0;
      repeat (3) @(negedge clk);

      // clear and capture on the same edge
      clear_and_set(50);
      conv_en = 1'b1;
      repeat (80) @(negedge clk);
      exp_q.push_back(52);
      conv_en = 1'b0;
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk("R2 clear wins on code", int'(dac_code), 0);
      chk("R2 clear drops done", int'(done), 0);
      chk("R8 pre-clear count captured", int'(result), 52);
      repeat (3) @(negedge clk);
      chk("R8 result unchanged after clear", int'(result), 52);

      chk("R8 all captures seen", exp_q.size(), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule